// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

Five software localities share one register interface, and only one of them may drive it at a time. This block decides which one that is. Each access carries its locality in address bits 14:12, so locality n sees its own 4 KiB window. Every window holds a one-byte access register at word offset 0. Through that register a locality can ask for ownership, hand ownership back, take it by force, or acknowledge that it was taken away.

Ownership can pass in three ways. A request wins at once when nobody owns the interface. A release by the owner passes ownership to the highest-numbered waiting requester. A seize by a higher-numbered locality takes ownership from the current owner. If a command is executing when a release or seize would move ownership, the block does not switch at once. It raises an abort request toward the command engine, naming the locality that will take over, and completes the switch only when the engine returns its abort acknowledge. Every actual change of owner is announced by a one-cycle pulse.

Top module: `loc_arbiter`

## Requirements
- R1: After reset, `owner` is 0xFF (no owner), `abort_req` and `owner_changed` are 0, and the access register of every locality 0..4 reads 0x80 with bit 0 equal to the inverse of `established`. Access byte bits are: 7 always 1, 5 this locality owns, 4 was seized, 3 seize (always reads 0), 2 another locality is requesting, 1 this locality is requesting, 0 inverse of `established`.
- R2: A write with bit 1 set, from a locality that is not the owner while no locality owns the interface, makes that locality the owner at the next clock edge.
- R3: A write with bit 1 set, from a non-owner while another locality owns the interface, sets that locality's request flag. Every other locality's window then reads bit 2 as 1.
- R4: A write with bit 5 set by the owner releases ownership. The highest-numbered locality with its request flag set becomes owner and its request flag clears; if none is requesting, `owner` becomes 0xFF. The old owner ends with bits 5 and 1 both 0.
- R5: A write with bit 5 set by a locality that is not the owner clears that locality's own request flag and leaves `owner` unchanged.
- R6: A write with bit 3 set is honoured only when nobody owns the interface or the writer's number is above the owner's. The writer then becomes owner and the old owner reads bit 4 as 1. In a seize write, bits 5 and 1 of the written byte are disregarded.
- R7: A seize is refused when the writer is at or below the owner, and when a higher locality already has a seize waiting. A newer, higher seize cancels a waiting lower one and takes its place as the handover target.
- R8: Writing bit 4 as 1 to a locality's access register clears that locality's was-seized flag.
- R9: Every write that falls in the locality-4 window (address bits 14:12 = 4) is ignored. Reads of that window are served as usual.
- R10: If `cmd_busy` is 1 when a release or a seize would move ownership, `abort_req` rises after that edge with `abort_loc` naming the target, and `owner` stays unchanged. The switch happens at the edge where `abort_done` is seen, and `abort_req` drops at that same edge. While a handover waits, writes of bits 5 and 1 are ignored.
- R11: `owner_changed` is high for exactly the one cycle after each edge at which `owner` takes a different value, and is low otherwise.
- R12: Writes with `bus_be[0]` = 0, or aimed at any word offset other than 0, change nothing. Reads at any other offset, and reads in the windows for localities 5..7, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 15 | Byte address; bits 14:12 select the locality |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_be | input | 4 | Byte enables; lane 0 carries the access byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` and state |
| established | input | 1 | Platform flag, reflected inverted in access bit 0 |
| cmd_busy | input | 1 | Command engine is executing a command |
| abort_done | input | 1 | Command engine has finished the requested abort |
| abort_req | output | 1 | Abort wanted before a waiting handover can complete |
| abort_loc | output | 3 | Locality that takes over once the abort is acknowledged |
| owner | output | 8 | Owning locality, 0xFF when none |
| owner_changed | output | 1 | One-cycle pulse after each change of owner |

## Verification
Reads are combinational, so an access byte is sampled at a falling edge with no clock edge between the stimulus and the read. A write, or an `abort_done`, is taken at one rising edge. Its effect on `owner`, `abort_req`, `abort_loc` and the access bytes is checked at the next falling edge. `owner_changed` is checked high at that same falling edge and low one cycle later, which pins it to a single cycle. The release and seize sweeps cover every owner and every combination of requesters or seizer among localities 0..3, and compute the expected winner and flag bytes arithmetically.

// File: rtl/lta_pkg.sv
package lta_pkg;
    localparam int OWN_W = 8;
    localparam logic [OWN_W-1:0] NO_OWNER = 8'hFF;

    // access byte bit positions (software-visible layout)
    localparam int B_EST    = 0;
    localparam int B_REQ    = 1;
    localparam int B_PEND   = 2;
    localparam int B_SEIZE  = 3;
    localparam int B_SEIZED = 4;
    localparam int B_ACT    = 5;
    localparam int B_VALID  = 7;

    typedef enum logic {
        HAND_RELEASE = 1'b0,
        HAND_SEIZE   = 1'b1
    } hand_kind_e;
endpackage

// File: rtl/lta_decode.sv
module lta_decode #(
    parameter int ADDR_W    = 15,
    parameter int LOC_SHIFT = 12,
    parameter int NLOC      = 5,
    parameter int LOC_W     = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [LOC_W-1:0]  loc,
    output logic              loc_ok,
    output logic              reg_hit,
    output logic              wr_lock
);
    always_comb begin
        loc     = addr[LOC_SHIFT+LOC_W-1:LOC_SHIFT];
        loc_ok  = (int'(loc) < NLOC);
        reg_hit = (addr[LOC_SHIFT-1:2] == '0);
        // the top locality window is read-only to software
        wr_lock = (int'(loc) == NLOC - 1);
    end
endmodule

// File: rtl/lta_pick_high.sv
module lta_pick_high #(
    parameter int NLOC  = 5,
    parameter int LOC_W = 3
) (
    input  logic [NLOC-1:0]  mask,
    output logic             found,
    output logic [LOC_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NLOC; i++) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = LOC_W'(i);
            end
        end
    end
endmodule

// File: rtl/lta_regview.sv
module lta_regview
    import lta_pkg::*;
#(
    parameter int NLOC   = 5,
    parameter int LOC_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic [LOC_W-1:0]  loc,
    input  logic              loc_ok,
    input  logic              reg_hit,
    input  logic [NLOC-1:0]   req,
    input  logic [NLOC-1:0]   seized,
    input  logic [OWN_W-1:0]  owner,
    input  logic              established,
    output logic [DATA_W-1:0] rdata
);
    logic [NLOC-1:0] others_req;
    logic [7:0]      acc;

    genvar g;
    generate
        for (g = 0; g < NLOC; g++) begin : g_pend
            localparam logic [NLOC-1:0] SELF = NLOC'(1) << g;
            assign others_req[g] = |(req & ~SELF);
        end
    endgenerate

    always_comb begin
        acc           = '0;
        acc[B_VALID]  = 1'b1;
        acc[B_EST]    = ~established;
        if (loc_ok) begin
            acc[B_ACT]    = (owner == OWN_W'(loc));
            acc[B_SEIZED] = seized[loc];
            acc[B_PEND]   = others_req[loc];
            acc[B_REQ]    = req[loc];
        end
        rdata = (loc_ok && reg_hit) ? DATA_W'(acc) : '0;
    end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
    import lta_pkg::*;
#(
    parameter int NLOC      = 5,
    parameter int ADDR_W    = 15,
    parameter int LOC_SHIFT = 12,
    parameter int DATA_W    = 32,
    localparam int LOC_W    = $clog2(NLOC),
    localparam int BE_W     = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              established,
    input  logic              cmd_busy,
    input  logic              abort_done,
    output logic              abort_req,
    output logic [LOC_W-1:0]  abort_loc,
    output logic [OWN_W-1:0]  owner,
    output logic              owner_changed
);
    typedef struct packed {
        logic [NLOC-1:0]  req;
        logic [NLOC-1:0]  seize;
        logic [NLOC-1:0]  seized;
        logic [OWN_W-1:0] owner;
        logic             pend;
        logic [LOC_W-1:0] pend_tgt;
        hand_kind_e       pend_kind;
        logic             chg;
    } arb_state_t;

    arb_state_t q, d;

    logic [LOC_W-1:0] dec_loc;
    logic             loc_ok, reg_hit, wr_lock;
    logic             pick_found;
    logic [LOC_W-1:0] pick_idx;

    lta_decode #(
        .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .NLOC(NLOC), .LOC_W(LOC_W)
    ) u_dec (
        .addr(bus_addr), .loc(dec_loc), .loc_ok(loc_ok),
        .reg_hit(reg_hit), .wr_lock(wr_lock)
    );

    lta_pick_high #(.NLOC(NLOC), .LOC_W(LOC_W)) u_pick (
        .mask(q.req), .found(pick_found), .idx(pick_idx)
    );

    lta_regview #(.NLOC(NLOC), .LOC_W(LOC_W), .DATA_W(DATA_W)) u_view (
        .loc(dec_loc), .loc_ok(loc_ok), .reg_hit(reg_hit),
        .req(q.req), .seized(q.seized), .owner(q.owner),
        .established(established), .rdata(bus_rdata)
    );

    logic             wr_ok, owner_valid, is_owner, seize_ok;
    logic [7:0]       wv;
    logic [NLOC-1:0]  hi_mask, lo_mask;
    logic             do_apply;
    logic [OWN_W-1:0] ap_tgt;
    hand_kind_e       ap_kind;
    logic             hand;
    logic [LOC_W-1:0] h_tgt;
    hand_kind_e       h_kind;

    always_comb begin
        d     = q;
        d.chg = 1'b0;

        do_apply = 1'b0;
        ap_tgt   = NO_OWNER;
        ap_kind  = HAND_RELEASE;
        hand     = 1'b0;
        h_tgt    = '0;
        h_kind   = HAND_RELEASE;

        wr_ok       = bus_wr && bus_be[0] && reg_hit && loc_ok && !wr_lock;
        wv          = bus_wdata[7:0];
        // a seize write disregards its request and release bits
        if (wv[B_SEIZE]) begin
            wv[B_REQ] = 1'b0;
            wv[B_ACT] = 1'b0;
        end
        owner_valid = (q.owner < OWN_W'(NLOC));
        is_owner    = owner_valid && (q.owner == OWN_W'(dec_loc));

        for (int i = 0; i < NLOC; i++) begin
            hi_mask[i] = (i > int'(dec_loc));
            lo_mask[i] = (i < int'(dec_loc));
        end

        seize_ok = wv[B_SEIZE]
                && (!owner_valid || (OWN_W'(dec_loc) > q.owner))
                && !q.seize[dec_loc]
                && !(|(q.seize & hi_mask));

        if (q.pend) begin
            if (abort_done) begin
                do_apply = 1'b1;
                ap_tgt   = OWN_W'(q.pend_tgt);
                ap_kind  = q.pend_kind;
                d.pend   = 1'b0;
            end else if (wr_ok) begin
                if (wv[B_SEIZED]) begin
                    d.seized[dec_loc] = 1'b0;
                end
                if (seize_ok) begin
                    d.seize          = d.seize & ~lo_mask;
                    d.seize[dec_loc] = 1'b1;
                    d.pend_tgt       = dec_loc;
                    d.pend_kind      = HAND_SEIZE;
                end
            end
        end else if (wr_ok) begin
            if (wv[B_ACT]) begin
                if (is_owner) begin
                    if (pick_found) begin
                        hand   = 1'b1;
                        h_tgt  = pick_idx;
                        h_kind = HAND_RELEASE;
                    end else begin
                        do_apply = 1'b1;
                        ap_tgt   = NO_OWNER;
                        ap_kind  = HAND_RELEASE;
                    end
                end else begin
                    d.req[dec_loc] = 1'b0;
                end
            end

            if (wv[B_SEIZED]) begin
                d.seized[dec_loc] = 1'b0;
            end

            if (seize_ok) begin
                d.seize          = d.seize & ~lo_mask;
                d.seize[dec_loc] = 1'b1;
                hand             = 1'b1;
                h_tgt            = dec_loc;
                h_kind           = HAND_SEIZE;
            end

            if (wv[B_REQ] && !is_owner) begin
                if (owner_valid) begin
                    d.req[dec_loc] = 1'b1;
                end else begin
                    do_apply = 1'b1;
                    ap_tgt   = OWN_W'(dec_loc);
                    ap_kind  = HAND_RELEASE;
                end
            end

            if (hand) begin
                if (cmd_busy) begin
                    d.pend      = 1'b1;
                    d.pend_tgt  = h_tgt;
                    d.pend_kind = h_kind;
                end else begin
                    do_apply = 1'b1;
                    ap_tgt   = OWN_W'(h_tgt);
                    ap_kind  = h_kind;
                end
            end
        end

        if (do_apply) begin
            if (ap_tgt != q.owner) begin
                d.chg = 1'b1;
                if (owner_valid) begin
                    if (ap_kind == HAND_SEIZE) begin
                        d.seized[q.owner[LOC_W-1:0]] = 1'b1;
                    end else begin
                        d.req[q.owner[LOC_W-1:0]] = 1'b0;
                    end
                end
            end
            d.owner = ap_tgt;
            if (ap_tgt < OWN_W'(NLOC)) begin
                d.req[ap_tgt[LOC_W-1:0]]   = 1'b0;
                d.seize[ap_tgt[LOC_W-1:0]] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.req       <= '0;
            q.seize     <= '0;
            q.seized    <= '0;
            q.owner     <= NO_OWNER;
            q.pend      <= 1'b0;
            q.pend_tgt  <= '0;
            q.pend_kind <= HAND_RELEASE;
            q.chg       <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign abort_req     = q.pend;
    assign abort_loc     = q.pend_tgt;
    assign owner         = q.owner;
    assign owner_changed = q.chg;
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk #(
    parameter int NLOC      = 5,
    parameter int ADDR_W    = 15,
    parameter int LOC_SHIFT = 12,
    parameter int LOC_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              abort_done,
    input logic              abort_req,
    input logic [LOC_W-1:0]  abort_loc,
    input logic [7:0]        owner,
    input logic              owner_changed
);
    a_r1_owner_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == 8'hFF) || (int'(owner) < NLOC));

    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req && !abort_done |=> abort_req);

    a_r10_owner_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req && !abort_done |=> $stable(owner));

    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req && abort_done |=> !abort_req);

    a_r10_target_legal: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> (int'(abort_loc) < NLOC));

    a_r11_change_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != $past(owner)) |-> owner_changed);

    a_r11_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        owner_changed |-> (owner != $past(owner)));

    a_r9_lock_window: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !abort_req
        && (int'(bus_addr[LOC_SHIFT+LOC_W-1:LOC_SHIFT]) == NLOC - 1)
        |=> $stable(owner));
endmodule

bind loc_arbiter loc_arbiter_chk #(
    .NLOC(NLOC), .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT), .LOC_W(LOC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .abort_done(abort_done), .abort_req(abort_req), .abort_loc(abort_loc),
    .owner(owner), .owner_changed(owner_changed)
);

// File: tb/sim_loc_arbiter.sv
`timescale 1ns/1ps
module sim_loc_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        established = 1'b1;
    logic        cmd_busy = 1'b0;
    logic        abort_done = 1'b0;
    logic        abort_req;
    logic [2:0]  abort_loc;
    logic [7:0]  owner;
    logic        owner_changed;

    int nchk = 0;
    int nbad = 0;

    always #4 clk = ~clk;

    loc_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .established(established), .cmd_busy(cmd_busy),
        .abort_done(abort_done), .abort_req(abort_req),
        .abort_loc(abort_loc), .owner(owner), .owner_changed(owner_changed)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int loc, input logic [7:0] val,
                      input logic [3:0] be = 4'h1, input logic [11:0] off = '0);
        @(negedge clk);
        bus_addr  = {loc[2:0], off};
        bus_be    = be;
        bus_wdata = {24'h0, val};
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_be    = '0;
    endtask

    function automatic int rd(input int loc, input logic [11:0] off = '0);
        bus_addr = {loc[2:0], off};
        return 0;
    endfunction

    task automatic rdchk(input string tag, input int loc, input int exp,
                         input logic [11:0] off = '0);
        int dummy;
        dummy = rd(loc, off);
        #1;
        chk(tag, int'(bus_rdata), exp);
    endtask

    function automatic int accv(input bit own, input bit sz, input bit pend,
                                input bit rq);
        return 32'h80 | (own ? 32'h20 : 0) | (sz ? 32'h10 : 0)
             | (pend ? 32'h4 : 0) | (rq ? 32'h2 : 0) | (established ? 0 : 1);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        // R1 reset state
        established = 1'b0;
        do_reset();
        chk("R1 owner", owner, 8'hFF);
        chk("R1 abort_req", abort_req, 0);
        chk("R1 owner_changed", owner_changed, 0);
        for (int l = 0; l < 5; l++) rdchk("R1 access est0", l, 32'h81);
        established = 1'b1;
        #1;
        for (int l = 0; l < 5; l++) rdchk("R1 access est1", l, 32'h80);

        // R12 byte enable, offset, unused windows
        wr(1, 8'h02, 4'h2);
        chk("R12 be0 low ignored", owner, 8'hFF);
        wr(1, 8'h02, 4'h1, 12'h018);
        chk("R12 other offset ignored", owner, 8'hFF);
        rdchk("R12 other offset reads 0", 1, 0, 12'h004);
        rdchk("R12 window 6 reads 0", 6, 0);

        // R9 locality-4 window writes ignored
        wr(4, 8'h02);
        chk("R9 write ignored", owner, 8'hFF);
        rdchk("R9 read served", 4, accv(0, 0, 0, 0));

        // R2 immediate grant, R11 pulse
        wr(2, 8'h02);
        chk("R2 owner", owner, 2);
        chk("R11 pulse high", owner_changed, 1);
        rdchk("R2 access", 2, accv(1, 0, 0, 0));
        @(negedge clk);
        chk("R11 pulse low", owner_changed, 0);

        // R3 request while owned, R5 non-owner withdraw
        wr(1, 8'h02);
        chk("R3 owner kept", owner, 2);
        chk("R11 no pulse", owner_changed, 0);
        rdchk("R3 req flag", 1, accv(0, 0, 0, 1));
        rdchk("R3 pending seen", 2, accv(1, 0, 1, 0));
        wr(1, 8'h20);
        rdchk("R5 req cleared", 1, accv(0, 0, 0, 0));
        rdchk("R5 pending gone", 2, accv(1, 0, 0, 0));
        chk("R5 owner kept", owner, 2);

        // R4 release sweep: every owner, every requester subset
        for (int o = 0; o < 4; o++) begin
            for (int m = 0; m < 16; m++) begin
                int nw;
                int rest;
                if (m[o]) continue;
                do_reset();
                wr(o, 8'h02);
                for (int r = 0; r < 4; r++) if (m[r]) wr(r, 8'h02);
                rdchk("R3 pending sweep", o, accv(1, 0, m != 0, 0));
                nw = -1;
                for (int r = 0; r < 4; r++) if (m[r]) nw = r;
                wr(o, 8'h20);
                chk("R4 new owner", owner, (nw < 0) ? 8'hFF : nw);
                chk("R11 release pulse", owner_changed, 1);
                rest = (nw < 0) ? 0 : (m & ~(1 << nw));
                rdchk("R4 old owner", o, accv(0, 0, rest != 0, 0));
                if (nw >= 0) rdchk("R4 winner", nw, accv(1, 0, rest != 0, 0));
            end
        end

        // R6/R7 seize sweep, plus R8 been-seized clear
        for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 4; s++) begin
                do_reset();
                wr(o, 8'h02);
                wr(s, 8'h0A);
                if (s > o) begin
                    chk("R6 seize taken", owner, s);
                    chk("R11 seize pulse", owner_changed, 1);
                    rdchk("R6 old seized", o, accv(0, 1, 0, 0));
                    rdchk("R6 seizer", s, accv(1, 0, 0, 0));
                    wr(o, 8'h10);
                    rdchk("R8 seized cleared", o, accv(0, 0, 0, 0));
                end else begin
                    chk("R7 seize refused", owner, o);
                    rdchk("R7 seize reads 0", s, accv(s == o, 0, 0, 0));
                end
            end
        end
        do_reset();
        wr(3, 8'h08);
        chk("R6 seize with no owner", owner, 3);

        // R10 deferred seize with retargeting (R7)
        do_reset();
        wr(0, 8'h02);
        cmd_busy = 1'b1;
        wr(2, 8'h08);
        chk("R10 abort_req", abort_req, 1);
        chk("R10 abort_loc", abort_loc, 2);
        chk("R10 owner held", owner, 0);
        wr(1, 8'h08);
        chk("R7 lower refused", abort_loc, 2);
        wr(3, 8'h08);
        chk("R7 higher retargets", abort_loc, 3);
        wr(1, 8'h02);
        repeat (3) @(negedge clk);
        chk("R10 still waiting", owner, 0);
        abort_done = 1'b1;
        @(negedge clk);
        abort_done = 1'b0;
        chk("R10 applied", owner, 3);
        chk("R10 abort dropped", abort_req, 0);
        chk("R11 deferred pulse", owner_changed, 1);
        rdchk("R10 old seized", 0, accv(0, 1, 0, 0));
        rdchk("R10 request ignored", 1, accv(0, 0, 0, 0));
        rdchk("R7 cancelled seize", 2, accv(0, 0, 0, 0));

        // R10 deferred release
        wr(1, 8'h02);
        wr(3, 8'h20);
        chk("R10 release deferred", owner, 3);
        chk("R10 release target", abort_loc, 1);
        abort_done = 1'b1;
        @(negedge clk);
        abort_done = 1'b0;
        cmd_busy = 1'b0;
        chk("R10 release applied", owner, 1);
        rdchk("R4 old after deferred", 3, accv(0, 0, 0, 0));

        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule